// File: doc/BRIEF.md
# Cascaded Look-Up Table Cell with Reusable Table Storage

This block is one configurable logic cell. Two sixteen-entry truth tables, called the first table and the second table, each take their own four-bit input and give one bit. Those two bits, together with one more bit taken from a control pin, address an eight-entry output table. Two flip-flops sit behind the tables. Each one loads, under a clock enable, a value picked by configuration from the first table, the second table, the output table or a direct data bit.

Four shared control pins feed four internal signals: the output-table third input, the direct data bit, the clock enable and an asynchronous force signal for the flip-flops. Each internal signal picks one pin through its own two-bit selector. The two sixteen-entry tables load from configuration ports during synchronous reset. Software can then use them as writable storage in one of two ways. In dual mode they form two independent 16x1 memories. In wide mode they form one 32x1 memory. In both memory modes the write data, the write strobe and the wide-mode upper address bit come from the mapped control signals. Writes take place on the clock edge and reads are combinational.

Top module: `lut_cascade_cell`

## Requirements
- R1: While `rst_n` is low at a rising edge, the first table loads `cfg_f_init`, the second table loads `cfg_g_init` and each flip-flop loads its force value (`cfg_force_x`, `cfg_force_y`).
- R2: In logic mode (`cfg_mode` = 0, and also 3), `f_out` equals bit `f_in` of the first table and `g_out` equals bit `g_in` of the second table. Both are combinational.
- R3: `h_out` equals bit {h1, g_out, f_out} of `cfg_h_tbl`, with h1 as the most significant address bit.
- R4: Each internal signal equals `ctl[sel]`, where sel is its own selector: `cfg_sel_h1` for h1, `cfg_sel_din` for the data bit, `cfg_sel_ce` for the clock enable and `cfg_sel_frc` for the force signal.
- R5: In logic mode, a clock edge with the enable high changes neither table.
- R6: In dual mode (`cfg_mode` = 1), a rising edge with the enable high writes the data bit into the first table at `f_in` and into the second table at `g_in`. With the enable low, nothing is written. The new contents appear on `f_out` and `g_out` with no further edge.
- R7: In wide mode (`cfg_mode` = 2), the 32-entry address is {h1, f_in}. When h1 is 0 a write goes to the first table, and when h1 is 1 it goes to the second table. `f_out` reads the word at {h1, f_in}, and `g_out` still reads the second table at `g_in`.
- R8: On a rising edge with the enable high and the force signal low, flip-flop X loads the source picked by `cfg_dsel_x` and Y loads the source picked by `cfg_dsel_y` (0 first table, 1 second table, 2 output table, 3 data bit). With the enable low, they hold.
- R9: A high force signal sets each flip-flop to its force value at once, without waiting for an edge, and holds it across edges even while the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, loads table contents |
| f_in | input | 4 | First-table address |
| g_in | input | 4 | Second-table address |
| ctl | input | 4 | Shared control pins |
| cfg_f_init | input | 16 | Reset contents of the first table |
| cfg_g_init | input | 16 | Reset contents of the second table |
| cfg_h_tbl | input | 8 | Output-table contents |
| cfg_sel_h1 | input | 2 | Pin selector for the output-table third input |
| cfg_sel_din | input | 2 | Pin selector for the data bit |
| cfg_sel_ce | input | 2 | Pin selector for the clock enable / write strobe |
| cfg_sel_frc | input | 2 | Pin selector for the force signal |
| cfg_mode | input | 2 | 0 logic, 1 dual 16x1 memory, 2 wide 32x1 memory, 3 logic |
| cfg_dsel_x | input | 2 | Source of flip-flop X |
| cfg_dsel_y | input | 2 | Source of flip-flop Y |
| cfg_force_x | input | 1 | Force and reset value of flip-flop X |
| cfg_force_y | input | 1 | Force and reset value of flip-flop Y |
| f_out | output | 1 | First-table (or wide memory) read |
| g_out | output | 1 | Second-table read |
| h_out | output | 1 | Output-table result |
| q_x | output | 1 | Flip-flop X |
| q_y | output | 1 | Flip-flop Y |

## Verification
Table reads and the output table have no register in their path. Their values are therefore due in the same cycle the address is driven, and they are checked 1 ns after inputs change at a falling edge. Memory writes and flip-flop loads take effect at the next rising edge. Inputs are driven at a falling edge and checked at the following falling edge, after exactly one rising edge. The force signal is asynchronous, so its effect is checked 1 ns after it rises, before any edge, and checked again after an edge has passed with the enable high.

// File: rtl/lcc_pkg.sv
// Shared types for the cascaded look-up table cell.
// Assumes two-bit encodings for the mode and the flip-flop source.
package lcc_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC    = 2'd0,
        MODE_RAM_DUAL = 2'd1,
        MODE_RAM_WIDE = 2'd2,
        MODE_LOGIC_B  = 2'd3
    } cell_mode_e;

    typedef enum logic [1:0] {
        DSRC_F   = 2'd0,
        DSRC_G   = 2'd1,
        DSRC_H   = 2'd2,
        DSRC_DIN = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic h1;
        logic din;
        logic ce;
        logic frc;
    } ctl_sig_t;

endpackage

// File: rtl/lcc_ctl_map.sv
// Control mapping: routes one shared pin to each internal control signal.
// Assumes the selector width covers every pin index.
module lcc_ctl_map
    import lcc_pkg::*;
#(
    parameter int NCTL = 4,
    localparam int SELW = $clog2(NCTL)
) (
    input  logic [NCTL-1:0] ctl,
    input  logic [SELW-1:0] sel_h1,
    input  logic [SELW-1:0] sel_din,
    input  logic [SELW-1:0] sel_ce,
    input  logic [SELW-1:0] sel_frc,
    output ctl_sig_t        sig
);

    // Pick one pin for each internal signal.
    always_comb begin
        sig.h1  = ctl[sel_h1];
        sig.din = ctl[sel_din];
        sig.ce  = ctl[sel_ce];
        sig.frc = ctl[sel_frc];
    end

endmodule

// File: rtl/lcc_lut_store.sv
// Storage of the two first-level tables. Reset loads the configured
// contents. In the memory modes the tables take single-bit writes on the
// rising edge, and reads are combinational.
// Assumes the mode stays stable outside reset.
module lcc_lut_store
    import lcc_pkg::*;
#(
    parameter  int LUT_IN = 4,
    localparam int DEPTH  = 1 << LUT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [DEPTH-1:0]  init_f,
    input  logic [DEPTH-1:0]  init_g,
    input  logic [LUT_IN-1:0] addr_f,
    input  logic [LUT_IN-1:0] addr_g,
    input  logic              ext_bit,
    input  logic              wr_data,
    input  logic              wr_en,
    output logic              rd_f,
    output logic              rd_g
);

    logic [DEPTH-1:0] tbl_f;
    logic [DEPTH-1:0] tbl_g;
    logic             is_dual;
    logic             is_wide;

    // Decode the memory mode.
    always_comb begin
        is_dual = (mode == MODE_RAM_DUAL);
        is_wide = (mode == MODE_RAM_WIDE);
    end

    // Load the tables at reset, then apply memory writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_f <= init_f;
            tbl_g <= init_g;
        end else if (wr_en) begin
            if (is_dual) begin
                tbl_f[addr_f] <= wr_data;
                tbl_g[addr_g] <= wr_data;
            end else if (is_wide) begin
                if (ext_bit) tbl_g[addr_f] <= wr_data;
                else         tbl_f[addr_f] <= wr_data;
            end
        end
    end

    // Combinational reads; in wide mode the upper bit picks the half.
    always_comb begin
        rd_f = (is_wide && ext_bit) ? tbl_g[addr_f] : tbl_f[addr_f];
        rd_g = tbl_g[addr_g];
    end

    assert_logic_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(is_dual) && !$past(is_wide) |-> $stable(tbl_f) && $stable(tbl_g));

    assert_dual_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en && is_dual)
        |-> tbl_f[$past(addr_f)] == $past(wr_data) && tbl_g[$past(addr_g)] == $past(wr_data));

    assert_wide_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en && is_wide) && is_wide
        && addr_f == $past(addr_f) && ext_bit == $past(ext_bit) |-> rd_f == $past(wr_data));

endmodule

// File: rtl/lcc_ff.sv
// Cell flip-flop with clock enable, synchronous active-low reset and an
// asynchronous force input that has priority over the clock enable.
// Assumes the force input is driven free of glitches.
module lcc_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic frc,
    input  logic en,
    input  logic d,
    input  logic frc_val,
    output logic q
);

    // Force asynchronously, reset synchronously, otherwise load under enable.
    always_ff @(posedge clk or posedge frc) begin
        if (frc)         q <= frc_val;
        else if (!rst_n) q <= frc_val;
        else if (en)     q <= d;
    end

    assert_force_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frc |-> q == frc_val);

    assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en && !frc) && !frc |-> q == $past(d));

    assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!en && !frc) && !frc |-> $stable(q));

endmodule

// File: rtl/lut_cascade_cell.sv
// Top of the cascaded look-up table cell: control mapping, table storage,
// the output table and two flip-flops with selectable sources.
// Assumes the configuration ports are static outside reset.
module lut_cascade_cell
    import lcc_pkg::*;
#(
    parameter  int LUT_IN = 4,
    parameter  int NCTL   = 4,
    localparam int DEPTH  = 1 << LUT_IN,
    localparam int SELW   = $clog2(NCTL),
    localparam int H_IN   = 3,
    localparam int H_DEP  = 1 << H_IN,
    localparam int NFF    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUT_IN-1:0] f_in,
    input  logic [LUT_IN-1:0] g_in,
    input  logic [NCTL-1:0]   ctl,
    input  logic [DEPTH-1:0]  cfg_f_init,
    input  logic [DEPTH-1:0]  cfg_g_init,
    input  logic [H_DEP-1:0]  cfg_h_tbl,
    input  logic [SELW-1:0]   cfg_sel_h1,
    input  logic [SELW-1:0]   cfg_sel_din,
    input  logic [SELW-1:0]   cfg_sel_ce,
    input  logic [SELW-1:0]   cfg_sel_frc,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_dsel_x,
    input  logic [1:0]        cfg_dsel_y,
    input  logic              cfg_force_x,
    input  logic              cfg_force_y,
    output logic              f_out,
    output logic              g_out,
    output logic              h_out,
    output logic              q_x,
    output logic              q_y
);

    ctl_sig_t         sig;
    logic [H_IN-1:0]  h_addr;
    logic [1:0]       dsel  [NFF];
    logic             fval  [NFF];
    logic             q_arr [NFF];

    lcc_ctl_map #(.NCTL(NCTL)) map_i (
        .ctl     (ctl),
        .sel_h1  (cfg_sel_h1),
        .sel_din (cfg_sel_din),
        .sel_ce  (cfg_sel_ce),
        .sel_frc (cfg_sel_frc),
        .sig     (sig)
    );

    lcc_lut_store #(.LUT_IN(LUT_IN)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg_mode),
        .init_f  (cfg_f_init),
        .init_g  (cfg_g_init),
        .addr_f  (f_in),
        .addr_g  (g_in),
        .ext_bit (sig.h1),
        .wr_data (sig.din),
        .wr_en   (sig.ce),
        .rd_f    (f_out),
        .rd_g    (g_out)
    );

    // Output table addressed by the mapped bit and both first-level results.
    always_comb begin
        h_addr = {sig.h1, g_out, f_out};
        h_out  = cfg_h_tbl[h_addr];
    end

    // Gather per-flip-flop configuration into arrays.
    always_comb begin
        dsel[0] = cfg_dsel_x;
        dsel[1] = cfg_dsel_y;
        fval[0] = cfg_force_x;
        fval[1] = cfg_force_y;
    end

    for (genvar i = 0; i < NFF; i++) begin : g_ff
        logic d_sel;

        // Pick this flip-flop's data source.
        always_comb begin
            unique case (dsrc_e'(dsel[i]))
                DSRC_F:   d_sel = f_out;
                DSRC_G:   d_sel = g_out;
                DSRC_H:   d_sel = h_out;
                default:  d_sel = sig.din;
            endcase
        end

        lcc_ff ff_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .frc     (sig.frc),
            .en      (sig.ce),
            .d       (d_sel),
            .frc_val (fval[i]),
            .q       (q_arr[i])
        );
    end

    // Drive the flip-flop outputs.
    always_comb begin
        q_x = q_arr[0];
        q_y = q_arr[1];
    end

endmodule

// File: tb/lut_cascade_cell_tb_top.sv
// Sweep-based bench for the cascaded look-up table cell. Inputs change at
// falling edges. Combinational results are checked 1 ns later, and
// registered results at the next falling edge.
module lut_cascade_cell_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] F_INIT = 16'hA3C5;
    localparam logic [15:0] G_INIT = 16'h5E19;
    localparam logic [7:0]  H_TBL  = 8'hB4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic [3:0] ctl = '0;
    logic [1:0] sel_h1 = 2'd0, sel_din = 2'd1, sel_ce = 2'd2, sel_frc = 2'd3;
    logic [1:0] mode = 2'd0;
    logic [1:0] dsel_x = 2'd0, dsel_y = 2'd0;
    logic [7:0] h_tbl = H_TBL;
    logic       frc_x = 1'b1, frc_y = 1'b0;
    logic       f_out, g_out, h_out, q_x, q_y;

    logic [15:0] mf, mg;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_cascade_cell dut_i (
        .clk(clk), .rst_n(rst_n), .f_in(f_in), .g_in(g_in), .ctl(ctl),
        .cfg_f_init(F_INIT), .cfg_g_init(G_INIT), .cfg_h_tbl(h_tbl),
        .cfg_sel_h1(sel_h1), .cfg_sel_din(sel_din), .cfg_sel_ce(sel_ce),
        .cfg_sel_frc(sel_frc), .cfg_mode(mode), .cfg_dsel_x(dsel_x),
        .cfg_dsel_y(dsel_y), .cfg_force_x(frc_x), .cfg_force_y(frc_y),
        .f_out(f_out), .g_out(g_out), .h_out(h_out), .q_x(q_x), .q_y(q_y)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // ctl bits with the default selectors: 0 h1, 1 data, 2 enable, 3 force.
    task automatic drive(input logic frc, input logic ce, input logic din, input logic h1);
        ctl = {frc, ce, din, h1};
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        mode = m; ctl = '0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mf = F_INIT; mg = G_INIT;
    endtask

    function automatic logic src(input logic [1:0] s, input logic f, input logic g,
                                 input logic h, input logic d);
        case (s)
            2'd0: return f;
            2'd1: return g;
            2'd2: return h;
            default: return d;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset loads tables and force values
        do_reset(2'd0);
        #1;
        chk("R1 q_x reset", q_x, frc_x);
        chk("R1 q_y reset", q_y, frc_y);

        // R2, R3: exhaustive sweep in logic mode
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int h = 0; h < 2; h++) begin
                    @(negedge clk);
                    f_in = 4'(a); g_in = 4'(b); drive(1'b0, 1'b0, 1'b0, 1'(h));
                    #1;
                    chk("R2 f_out", f_out, F_INIT[a]);
                    chk("R2 g_out", g_out, G_INIT[b]);
                    chk("R3 h_out", h_out, H_TBL[{1'(h), G_INIT[b], F_INIT[a]}]);
                end

        // R4: pin mapping, observed through h1 with a table equal to bit 2
        h_tbl = 8'hF0;
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                sel_h1 = 2'(s); ctl = 4'(c);
                #1;
                chk("R4 h1 mapping", h_out, ctl[s]);
            end
        @(negedge clk);
        sel_h1 = 2'd0; ctl = '0; h_tbl = H_TBL;

        // R5: writes ignored in logic mode
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = 4'(a); g_in = 4'(a); drive(1'b0, 1'b1, ~F_INIT[a], 1'b0);
        end
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = 4'(a); g_in = 4'(a);
            #1;
            chk("R5 f table unchanged", f_out, F_INIT[a]);
            chk("R5 g table unchanged", g_out, G_INIT[a]);
        end

        // R8: source select, load under enable, hold without it
        for (int ds = 0; ds < 4; ds++)
            for (int p = 0; p < 2; p++) begin
                logic ef, eg, eh, ed, ex, ey;
                logic [3:0] fa, ga;
                fa = 4'(ds * 3 + p * 7); ga = 4'(ds * 5 + p * 2 + 1);
                @(negedge clk);
                dsel_x = 2'(ds); dsel_y = 2'(3 - ds);
                f_in = fa; g_in = ga; drive(1'b0, 1'b1, 1'(p), 1'(ds[0]));
                ef = F_INIT[fa]; eg = G_INIT[ga]; ed = 1'(p);
                eh = H_TBL[{1'(ds[0]), eg, ef}];
                ex = src(2'(ds), ef, eg, eh, ed);
                ey = src(2'(3 - ds), ef, eg, eh, ed);
                @(negedge clk);
                drive(1'b0, 1'b0, ~1'(p), ~1'(ds[0]));
                f_in = ~fa; g_in = ~ga;
                #1;
                chk("R8 q_x load", q_x, ex);
                chk("R8 q_y load", q_y, ey);
                @(negedge clk);
                #1;
                chk("R8 q_x hold", q_x, ex);
                chk("R8 q_y hold", q_y, ey);
            end

        // R9: asynchronous force with priority over the enable
        @(negedge clk);
        dsel_x = 2'd3; dsel_y = 2'd0; f_in = 4'd0; drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk("R9 q_x before force", q_x, 1'b0);
        chk("R9 q_y before force", q_y, 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        #1;
        chk("R9 q_x forced at once", q_x, frc_x);
        chk("R9 q_y forced at once", q_y, frc_y);
        @(negedge clk);
        #1;
        chk("R9 q_x force beats enable", q_x, frc_x);
        chk("R9 q_y force beats enable", q_y, frc_y);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        chk("R9 q_x reloads after force", q_x, 1'b0);
        chk("R9 q_y reloads after force", q_y, 1'b1);

        // R6: dual 16x1 memories
        do_reset(2'd1);
        for (int a = 0; a < 16; a++) begin
            logic bit_w;
            bit_w = ~F_INIT[a] ^ 1'(a[1]);
            @(negedge clk);
            f_in = 4'(a); g_in = 4'(15 - a); drive(1'b0, 1'b1, bit_w, 1'b0);
            @(negedge clk);
            drive(1'b0, 1'b0, ~bit_w, 1'b0);
            mf[a] = bit_w; mg[15 - a] = bit_w;
            #1;
            chk("R6 f write visible", f_out, bit_w);
            chk("R6 g write visible", g_out, bit_w);
        end
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = 4'(a); g_in = 4'(a);
            #1;
            chk("R6 f readback", f_out, mf[a]);
            chk("R6 g readback", g_out, mg[a]);
        end

        // R7: wide 32x1 memory
        do_reset(2'd2);
        for (int a = 0; a < 32; a++) begin
            logic bit_w;
            bit_w = 1'(a[0] ^ a[2] ^ a[4]);
            @(negedge clk);
            f_in = 4'(a); drive(1'b0, 1'b1, bit_w, 1'(a[4]));
            @(negedge clk);
            drive(1'b0, 1'b0, 1'b0, 1'(a[4]));
            if (a[4]) mg[a[3:0]] = bit_w; else mf[a[3:0]] = bit_w;
        end
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            f_in = 4'(a); g_in = 4'(a); drive(1'b0, 1'b0, 1'b0, 1'(a[4]));
            #1;
            chk("R7 wide readback", f_out, a[4] ? mg[a[3:0]] : mf[a[3:0]]);
            chk("R7 g_out reads second table", g_out, mg[a[3:0]]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule